// File: doc/BRIEF.md
# Wavetable Voice Address Interpolator

This block plays one voice out of a byte-addressed sample memory. It holds a fixed-point playback position whose low 9 bits are a fraction. On every sample tick it moves that position by a programmed increment, either forward or backward. When the position crosses a programmed loop boundary, the block either wraps it to the other end of the loop, keeping the fraction, or turns the voice around.

After each tick the block issues a single read to the sample memory at the integer part of the new position. The memory returns four consecutive bytes, which hold two adjacent samples in either 8-bit or 16-bit little-endian format. The block blends the two samples linearly by the fraction and presents a signed 16-bit result together with a one-cycle valid strobe. Software sets up the voice through a small register write port.

Top module: `wave_voice`

## Requirements
- R1: After reset the voice is stopped and `sample_valid`, `mem_rd` and `sample` are all 0.
- R2: Register selects: 0/1 loop-start low/high, 2/3 loop-end low/high, 4/5 position low/high, 6 increment, 7 control. Each high-half write keeps only the low 13 bits of `wr_data`. The 29-bit position has its integer part in bits 28:9, and `mem_addr` carries that integer part.
- R3: A `tick` in cycle c puts a read with `mem_rd`=1 in cycle c+1. `sample_valid` is 1 for exactly one cycle, c+2.
- R4: In 8-bit mode (control bit 2 = 0), byte k of `mem_rdata[31:0]` (bits 8k+7:8k) is the byte at `mem_addr`+k. Each signed byte is scaled to w = byte*256. The output is w1 + floor((w2-w1)*frac/512), with w1 taken from byte 0 and w2 from byte 1.
- R5: In 16-bit mode (control bit 2 = 1), w1 = {byte1,byte0} and w2 = {byte3,byte2}, both signed. The same blend formula applies.
- R6: While running forward (control bit 6 = 0) with control bit 4 = 0, a stepped position at or beyond the loop end is replaced by loop start plus the stepped position's 9-bit fraction.
- R7: While running backward (control bit 6 = 1) with control bit 4 = 0, a stepped position below the loop start, or one that underflows zero, is replaced by loop end - 512 + fraction.
- R8: With control bit 4 = 1, a boundary crossing keeps the stepped position and reverses the direction used on the following ticks.
- R9: When control bit 0 = 1 the voice is stopped. A tick leaves the position unchanged, and the strobed sample is 0.
- R10: Without a boundary crossing, a tick sets the position to the old position plus the increment (forward) or minus it (backward). The fraction is carried into the integer part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 16 | Register write data |
| tick | input | 1 | Sample tick: advance the voice by one step |
| mem_rd | output | 1 | Sample memory read request |
| mem_addr | output | 20 | Byte address of the first of four bytes |
| mem_rdata | input | 32 | Four bytes returned one cycle after `mem_rd` |
| sample_valid | output | 1 | Output sample strobe |
| sample | output | 16 | Interpolated signed sample |

## Verification
The properties assume a fixed spacing between ticks: each tick is followed by at least two idle cycles, so a read and its strobe never overlap the next step. They also assume that no register write falls in the same cycle as a tick. The memory must answer each read one cycle later with the four bytes at the requested address. The directed stimulus respects all of these conditions. It programs the voice only while the voice is idle, then issues one tick at a time and waits three cycles before the next.

// File: rtl/wave_voice.sv
module wave_voice #(
  parameter int INT_W  = 20,
  parameter int FRAC_W = 9,
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [15:0]       wr_data,
  input  logic              tick,
  output logic              mem_rd,
  output logic [INT_W-1:0]  mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              sample_valid,
  output logic [15:0]       sample
);
  localparam int A_W  = INT_W + FRAC_W;
  localparam int A_W1 = A_W + 1;
  localparam int HI_W = A_W - 16;

  logic [A_W-1:0]    start_q, end_q, cur_q, nxt;
  logic [STEP_W-1:0] step_q;
  logic stop_q, wide_q, bidir_q, bwd_q, nxt_bwd;
  logic rd_q, out_q, wide_l, stop_l;
  logic [FRAC_W-1:0] frac_q;

  wire [A_W:0] inc = {1'b0, cur_q} + A_W1'(step_q);
  wire [A_W:0] dec = {1'b0, cur_q} - A_W1'(step_q);
  wire past_end   = inc >= {1'b0, end_q};
  wire past_start = dec[A_W] || (dec[A_W-1:0] < start_q);
  wire [A_W-1:0] fwd_wrap = start_q + A_W'(inc[FRAC_W-1:0]);
  wire [A_W-1:0] bwd_wrap = end_q - A_W'(1 << FRAC_W) + A_W'(dec[FRAC_W-1:0]);

  always_comb begin
    nxt     = cur_q;
    nxt_bwd = bwd_q;
    if (!stop_q) begin
      if (!bwd_q) begin
        if (!past_end)     nxt = inc[A_W-1:0];
        else if (bidir_q) begin nxt = inc[A_W-1:0]; nxt_bwd = 1'b1; end
        else               nxt = fwd_wrap;
      end else begin
        if (!past_start)   nxt = dec[A_W-1:0];
        else if (bidir_q) begin nxt = dec[A_W-1:0]; nxt_bwd = 1'b0; end
        else               nxt = bwd_wrap;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0; end_q <= '0; cur_q <= '0; step_q <= '0;
      stop_q <= 1'b1; wide_q <= 1'b0; bidir_q <= 1'b0; bwd_q <= 1'b0;
      rd_q <= 1'b0; out_q <= 1'b0; wide_l <= 1'b0; stop_l <= 1'b1;
      frac_q <= '0;
    end else begin
      rd_q  <= tick;
      out_q <= rd_q;
      if (rd_q) begin
        frac_q <= cur_q[FRAC_W-1:0];
        wide_l <= wide_q;
        stop_l <= stop_q;
      end
      if (tick) begin
        cur_q <= nxt;
        bwd_q <= nxt_bwd;
      end
      if (wr_en) begin
        case (wr_sel)
          3'd0: start_q[15:0]    <= wr_data;
          3'd1: start_q[A_W-1:16] <= wr_data[HI_W-1:0];
          3'd2: end_q[15:0]      <= wr_data;
          3'd3: end_q[A_W-1:16]  <= wr_data[HI_W-1:0];
          3'd4: cur_q[15:0]      <= wr_data;
          3'd5: cur_q[A_W-1:16]  <= wr_data[HI_W-1:0];
          3'd6: step_q           <= wr_data[STEP_W-1:0];
          default: begin
            stop_q  <= wr_data[0];
            wide_q  <= wr_data[2];
            bidir_q <= wr_data[4];
            bwd_q   <= wr_data[6];
          end
        endcase
      end
    end
  end

  assign mem_rd       = rd_q;
  assign mem_addr     = cur_q[A_W-1:FRAC_W];
  assign sample_valid = out_q;

  wire [7:0] b0 = mem_rdata[7:0];
  wire [7:0] b1 = mem_rdata[15:8];
  wire [7:0] b2 = mem_rdata[23:16];
  wire [7:0] b3 = mem_rdata[31:24];
  wire [15:0] w1 = wide_l ? {b1, b0} : {b0, 8'h00};
  wire [15:0] w2 = wide_l ? {b3, b2} : {b1, 8'h00};
  wire signed [16:0] diff = $signed({w2[15], w2}) - $signed({w1[15], w1});
  wire signed [26:0] prod = 27'(diff) * 27'($signed({1'b0, frac_q}));
  wire signed [26:0] part = prod >>> FRAC_W;
  wire [15:0] blend = w1 + part[15:0];

  assign sample = (out_q && !stop_l) ? blend : 16'h0000;
endmodule

module wave_voice_chk #(
  parameter int A_W    = 29,
  parameter int STEP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr_en,
  input logic              mem_rd,
  input logic              sample_valid,
  input logic              stopped,
  input logic              backward,
  input logic [A_W-1:0]    cur,
  input logic [A_W-1:0]    lim_end,
  input logic [STEP_W-1:0] step
);
  AST_READ_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    tick |=> mem_rd); // R3
  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> sample_valid); // R3
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> $past(mem_rd)); // R3
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (stopped && !wr_en) |=> $stable(cur)); // R9
  AST_FWD_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (tick && !stopped && !backward && !wr_en &&
     (({1'b0, cur} + (A_W+1)'(step)) < {1'b0, lim_end}))
    |=> cur == $past(cur) + A_W'($past(step))); // R10
endmodule

bind wave_voice wave_voice_chk #(.A_W(A_W), .STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .mem_rd(mem_rd),
  .sample_valid(sample_valid), .stopped(stop_q), .backward(bwd_q),
  .cur(cur_q), .lim_end(end_q), .step(step_q)
);

// File: tb/wave_voice_test.sv
module wave_voice_test;
  logic clk = 0, rst = 1;
  logic wr_en = 0, tick = 0;
  logic [2:0] wr_sel = 0;
  logic [15:0] wr_data = 0;
  logic mem_rd, sample_valid;
  logic [19:0] mem_addr;
  logic [31:0] mem_rdata = 0;
  logic [15:0] sample;
  logic [7:0] ram [1024];
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  wave_voice uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick(tick), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .sample_valid(sample_valid), .sample(sample)
  );

  always @(posedge clk)
    if (mem_rd)
      mem_rdata <= {ram[(mem_addr+3)&1023], ram[(mem_addr+2)&1023],
                    ram[(mem_addr+1)&1023], ram[mem_addr&1023]};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int ref_sample(int a, int fr, bit wide);
    int w1, w2;
    if (wide) begin
      w1 = int'($signed({ram[(a+1)&1023], ram[a&1023]}));
      w2 = int'($signed({ram[(a+3)&1023], ram[(a+2)&1023]}));
    end else begin
      w1 = int'($signed(ram[a&1023])) * 256;
      w2 = int'($signed(ram[(a+1)&1023])) * 256;
    end
    return w1 + (((w2 - w1) * fr) >>> 9);
  endfunction

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en = 1; wr_sel = 3'(sel); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic setup(input int s, input int e, input int c, input int st, input int ctl);
    wr(0, s & 16'hFFFF); wr(1, s >> 16);
    wr(2, e & 16'hFFFF); wr(3, e >> 16);
    wr(4, c & 16'hFFFF); wr(5, c >> 16);
    wr(6, st); wr(7, ctl);
  endtask

  task automatic fire(input int exp_addr, input int exp_s, input string req);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    chk(mem_rd === 1'b1, {req, " R3 read"}, mem_rd, 1);
    chk(mem_addr === 20'(exp_addr), {req, " R2 address"}, mem_addr, exp_addr);
    @(negedge clk);
    chk(sample_valid === 1'b1, {req, " R3 strobe"}, sample_valid, 1);
    chk(sample === 16'(exp_s), {req, " sample"}, sample, exp_s & 16'hFFFF);
    @(negedge clk);
    chk(sample_valid === 1'b0, {req, " R3 single pulse"}, sample_valid, 0);
  endtask

  task automatic t_reset;
    chk(sample_valid === 0 && mem_rd === 0 && sample === 0, "R1 reset", {sample_valid, mem_rd, sample}, 0);
  endtask

  task automatic t_fwd8;
    setup(32'h10 << 9, 32'h40 << 9, (32'h20 << 9) + 100, 384, 0);
    fire(32'h20, ref_sample(32'h20, 484, 0), "R4 R10 8-bit forward");
    fire(32'h21, ref_sample(32'h21, 356, 0), "R10 carry");
  endtask

  task automatic t_wide;
    setup(32'h10 << 9, 32'h40 << 9, (32'h30 << 9) + 300, 512, 32'h4);
    fire(32'h31, ref_sample(32'h31, 300, 1), "R5 16-bit");
  endtask

  task automatic t_fwd_wrap;
    setup((32'h10 << 9) + 50, 32'h40 << 9, (32'h3F << 9) + 200, 400, 0);
    fire(32'h10, ref_sample(32'h10, 138, 0), "R6 forward wrap");
  endtask

  task automatic t_bwd_wrap;
    setup((32'h10 << 9) + 50, 32'h40 << 9, (32'h10 << 9) + 100, 300, 32'h40);
    fire(32'h3F, ref_sample(32'h3F, 312, 0), "R7 backward wrap");
  endtask

  task automatic t_bidir;
    setup(32'h10 << 9, 32'h40 << 9, (32'h3F << 9) + 200, 400, 32'h10);
    fire(32'h40, ref_sample(32'h40, 88, 0), "R8 reverse at end");
    fire(32'h3F, ref_sample(32'h3F, 200, 0), "R8 now backward");
    setup((32'h10 << 9) + 50, 32'h40 << 9, (32'h10 << 9) + 100, 300, 32'h50);
    fire(32'h0F, ref_sample(32'h0F, 312, 0), "R8 reverse at start");
    fire(32'h10, ref_sample(32'h10, 100, 0), "R8 now forward");
  endtask

  task automatic t_stop;
    setup(32'h10 << 9, 32'h40 << 9, (32'h20 << 9) + 10, 400, 32'h1);
    fire(32'h20, 0, "R9 stopped");
    fire(32'h20, 0, "R9 still held");
    wr(7, 0);
    fire(32'h20, ref_sample(32'h20, 410, 0), "R9 resumed");
  endtask

  task automatic t_himask;
    wr(7, 1);
    wr(4, 0);
    wr(5, 16'hFFFF);
    fire(32'hFFF80, 0, "R2 high half masked");
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) ram[i] = 8'((i * 37 + 11) ^ (i >> 2));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_fwd8;
    t_wide;
    t_fwd_wrap;
    t_bwd_wrap;
    t_bidir;
    t_stop;
    t_himask;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule